// File: doc/BRIEF.md
# Front Panel Command Microsequencer

This block turns a press of one of eight front-panel command switches into a fixed series of control strobes for a stopped 8-bit processor. The switches are examine, examine next, deposit, deposit next, accumulator display, accumulator load, input and output. The pressed switch is encoded into a four-bit command code. That code becomes the upper half of an eight-bit sequence address, and a four-bit step counter supplies the lower half.

A combinational decode of the sequence address selects what each step does. A step fires one of eight strobes (S1 to S8), or one single-step clock pulse, or ends the sequence. Steps are paced by a slow internal tick, one step every `TICK_DIV` clocks, so a whole command takes on the order of a second at the default setting. When a command finishes, the address parks at 177 octal until the next press. The step counter only moves while the processor is stopped.

Top module: `fp_cmd_sequencer`

## Requirements
- R1: `cmd_code` is a registered copy of the code of the accepted switch, written as address bits 7..4. The codes are: key_n[0] examine 0111, key_n[1] examine next 1011, key_n[2] deposit 1101, key_n[3] deposit next 1110, key_n[4] accumulator display 0011, key_n[5] accumulator load 1001, key_n[6] input 1100, key_n[7] output 1010. It reads 1111 when no switch is low.
- R2: When several switch lines are low together, the lowest-indexed one is the one accepted.
- R3: A fresh press while parked and stopped produces a single-cycle `seq_clr` pulse. In that cycle `seq_busy` is high and `seq_addr` holds {code, 0000}.
- R4: The step counter advances once every `TICK_DIV` clocks, and only while `cpu_run` is low. While `cpu_run` is high, no strobe, step pulse or clear is issued, and a press made during that time starts nothing.
- R5: Over one command, each strobe bit (strobe[0] = S1 ... strobe[7] = S8) is high for exactly one cycle if it belongs to the command and never otherwise. The sets are: examine S1 S2 S5 S7 S8; examine next S5 S7 S8; deposit S1 S6 S7; deposit next S1 S5 S6 S7 S8; accumulator display S3 S4 S5 S7 S8; accumulator load S1 S3 S4 S5 S7; input S2 to S7; output S2 S3 S4 S5 S7 S8.
- R6: `step_pulse` is high for a number of single cycles per command: 3 for examine, 1 for examine next, 0 for deposit, 1 for deposit next, and 6 for each of the other four commands.
- R7: Within a command, strobes appear in ascending S index and all come before any step pulse. At most one strobe is high in a cycle, and never in the same cycle as a step pulse.
- R8: The highest step value reached equals the strobe count plus the pulse count, so deposit stays within 320 to 323 octal. After that step `seq_busy` falls and `seq_addr` reads 177 octal, both while the switch is held and after it is released.
- R9: Further presses while a sequence is running are ignored. A switch held past the end of its sequence does not start it again.
- R10: After reset, `seq_addr` is 177 octal, `cmd_code` is 1111, and `seq_busy`, `seq_clr`, `step_pulse` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_n | input | 8 | Active-low command switch lines, index = priority |
| cpu_run | input | 1 | High while the processor is running |
| strobe | output | 8 | Control strobes, bit i is S(i+1), registered |
| step_pulse | output | 1 | Single-step clock request, one cycle per pulse |
| seq_addr | output | 8 | Sequence address {code, step} |
| cmd_code | output | 4 | Code of the accepted switch, 1111 when none |
| seq_clr | output | 1 | One-cycle step counter clear at command start |
| seq_busy | output | 1 | High while a command sequence runs |

## Verification
The bench runs every command and compares the strobe set, the step-pulse total, the ordering, the peak step and the parking address against tables it holds itself. A decode that misplaced a strobe shows up as a wrong per-bit count or an order violation. A wrong terminal step would leave the pulse total off or the deposit step outside 0 to 3. Two presses are tried together, one switch lowered mid-sequence and a switch held past the end; a broken priority, busy lock or edge detector would start the wrong or an extra sequence. The run flag is raised both before a press and in the middle of a sequence, which catches a design that keeps stepping or accepts the press while the processor runs.

// File: rtl/fp_seq_pkg.sv
package fp_seq_pkg;
  localparam int NCMD   = 8;
  localparam int CODE_W = 4;
  localparam int STEP_W = 4;
  localparam int ADDR_W = CODE_W + STEP_W;
  localparam logic [CODE_W-1:0] CODE_NONE = 4'hF;
  localparam logic [ADDR_W-1:0] PARK_ADDR = 8'o177;

  typedef struct packed {
    logic [NCMD-1:0] strobe;
    logic            pulse;
    logic            last;
  } step_act_t;

  // Active-low upper address code of each command (index = switch line).
  function automatic logic [CODE_W-1:0] code_of(input int idx);
    case (idx)
      0: code_of = 4'b0111;
      1: code_of = 4'b1011;
      2: code_of = 4'b1101;
      3: code_of = 4'b1110;
      4: code_of = 4'b0011;
      5: code_of = 4'b1001;
      6: code_of = 4'b1100;
      7: code_of = 4'b1010;
      default: code_of = CODE_NONE;
    endcase
  endfunction

  // Strobe set per command, bit i = S(i+1).
  function automatic logic [NCMD-1:0] mask_of(input int idx);
    case (idx)
      0: mask_of = 8'hD3;
      1: mask_of = 8'hD0;
      2: mask_of = 8'h61;
      3: mask_of = 8'hF1;
      4: mask_of = 8'hDC;
      5: mask_of = 8'h5D;
      6: mask_of = 8'h7E;
      7: mask_of = 8'hDE;
      default: mask_of = 8'h00;
    endcase
  endfunction

  function automatic int pulses_of(input int idx);
    case (idx)
      0: pulses_of = 3;
      1: pulses_of = 1;
      2: pulses_of = 0;
      3: pulses_of = 1;
      default: pulses_of = 6;
    endcase
  endfunction
endpackage

// File: rtl/fp_key_encoder.sv
module fp_key_encoder
  import fp_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NCMD-1:0]   key_n,
  output logic [CODE_W-1:0] code,
  output logic              press
);
  logic [NCMD-1:0]   down;
  logic              any_down;
  logic              any_q;
  logic [CODE_W-1:0] code_c;

  assign down     = ~key_n;
  assign any_down = |down;

  // Lowest index wins: scan from the top so the last hit is the lowest.
  always_comb begin
    code_c = CODE_NONE;
    for (int i = NCMD - 1; i >= 0; i--) begin
      if (down[i]) code_c = code_of(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code  <= CODE_NONE;
      any_q <= 1'b0;
      press <= 1'b0;
    end else begin
      code  <= code_c;
      any_q <= any_down;
      press <= any_down && !any_q;
    end
  end

  p_idle_code_r1: assert property (@(posedge clk) disable iff (rst)
    (key_n == '1) |=> (code == CODE_NONE));
  p_press_valid_r2: assert property (@(posedge clk) disable iff (rst)
    press |-> (code != CODE_NONE));
  p_single_press_r9: assert property (@(posedge clk) disable iff (rst)
    press |=> !press);
endmodule

// File: rtl/fp_tick_gen.sv
module fp_tick_gen #(
  parameter int DIV = 8_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  input  logic hold,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      cnt <= '0;
    end else if (!hold) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign tick = run_en && !hold && (cnt == LAST);

  generate
    if (DIV > 1) begin : g_gap
      p_tick_gap_r4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/fp_step_decode.sv
module fp_step_decode
  import fp_seq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output step_act_t         act
);
  int step;
  int nstr;
  int total;
  int rank;
  logic found;

  always_comb begin
    act   = '0;
    found = 1'b0;
    step  = int'(addr[STEP_W-1:0]);
    nstr  = 0;
    total = 0;
    rank  = 0;
    for (int c = 0; c < NCMD; c++) begin
      if (addr[ADDR_W-1:STEP_W] == code_of(c)) begin
        found = 1'b1;
        nstr  = $countones(mask_of(c));
        total = nstr + pulses_of(c);
        rank  = 0;
        for (int i = 0; i < NCMD; i++) begin
          if (mask_of(c)[i]) begin
            if (rank == step) act.strobe[i] = 1'b1;
            rank = rank + 1;
          end
        end
        act.pulse = (step >= nstr) && (step < total);
        act.last  = (step >= total);
      end
    end
    if (!found) act.last = 1'b1;
  end

  always_comb begin
    p_decode_excl_r7: assert ($onehot0({act.strobe, act.pulse, act.last}));
  end
endmodule

// File: rtl/fp_cmd_sequencer.sv
module fp_cmd_sequencer
  import fp_seq_pkg::*;
#(
  parameter int TICK_DIV = 8_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCMD-1:0]   key_n,
  input  logic              cpu_run,
  output logic [NCMD-1:0]   strobe,
  output logic              step_pulse,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [CODE_W-1:0] cmd_code,
  output logic              seq_clr,
  output logic              seq_busy
);
  logic      press;
  logic      tick;
  step_act_t act;

  fp_key_encoder i_keys (
    .clk   (clk),
    .rst   (rst),
    .key_n (key_n),
    .code  (cmd_code),
    .press (press)
  );

  fp_tick_gen #(.DIV(TICK_DIV)) i_tick (
    .clk    (clk),
    .rst    (rst),
    .run_en (seq_busy),
    .hold   (cpu_run),
    .tick   (tick)
  );

  fp_step_decode i_dec (
    .addr (seq_addr),
    .act  (act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_addr   <= PARK_ADDR;
      seq_busy   <= 1'b0;
      seq_clr    <= 1'b0;
      strobe     <= '0;
      step_pulse <= 1'b0;
    end else begin
      seq_clr    <= 1'b0;
      strobe     <= '0;
      step_pulse <= 1'b0;
      if (!seq_busy) begin
        if (press && !cpu_run) begin
          seq_addr <= {cmd_code, {STEP_W{1'b0}}};
          seq_busy <= 1'b1;
          seq_clr  <= 1'b1;
        end
      end else if (tick) begin
        if (act.last) begin
          seq_addr <= PARK_ADDR;
          seq_busy <= 1'b0;
        end else begin
          strobe              <= act.strobe;
          step_pulse          <= act.pulse;
          seq_addr[STEP_W-1:0] <= seq_addr[STEP_W-1:0] + 1'b1;
        end
      end
    end
  end

  p_clr_start_r3: assert property (@(posedge clk) disable iff (rst)
    seq_clr |-> (seq_busy && seq_addr[STEP_W-1:0] == '0));
  p_run_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_run |=> (strobe == '0 && !step_pulse && !seq_clr));
  p_run_no_start_r4: assert property (@(posedge clk) disable iff (rst)
    (cpu_run && !seq_busy) |=> !seq_busy);
  p_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobe));
  p_strobe_not_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    !((strobe != '0) && step_pulse));
  p_park_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(seq_busy) |-> (seq_addr == PARK_ADDR));
  p_park_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!seq_busy && !press) |=> (seq_addr == PARK_ADDR));
  p_code_locked_r9: assert property (@(posedge clk) disable iff (rst)
    (seq_busy && !seq_clr && $past(seq_busy)) |-> $stable(seq_addr[ADDR_W-1:STEP_W]) || (seq_addr == PARK_ADDR));
endmodule

// File: tb/test_fp_cmd_sequencer.sv
module test_fp_cmd_sequencer;
  localparam int TDIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] key_n = 8'hFF;
  logic       cpu_run = 1'b0;
  logic [7:0] strobe;
  logic       step_pulse;
  logic [7:0] seq_addr;
  logic [3:0] cmd_code;
  logic       seq_clr;
  logic       seq_busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  fp_cmd_sequencer #(.TICK_DIV(TDIV)) i_fp_cmd_sequencer (
    .clk(clk), .rst(rst), .key_n(key_n), .cpu_run(cpu_run),
    .strobe(strobe), .step_pulse(step_pulse), .seq_addr(seq_addr),
    .cmd_code(cmd_code), .seq_clr(seq_clr), .seq_busy(seq_busy)
  );

  always #5 clk = ~clk;

  // Expected tables, written from the requirements.
  function automatic logic [3:0] e_code(input int i);
    logic [3:0] t [8] = '{4'b0111, 4'b1011, 4'b1101, 4'b1110,
                          4'b0011, 4'b1001, 4'b1100, 4'b1010};
    return t[i];
  endfunction
  function automatic logic [7:0] e_mask(input int i);
    logic [7:0] t [8] = '{8'b1101_0011, 8'b1101_0000, 8'b0110_0001, 8'b1111_0001,
                          8'b1101_1100, 8'b0101_1101, 8'b0111_1110, 8'b1101_1110};
    return t[i];
  endfunction
  function automatic int e_pulses(input int i);
    int t [8] = '{3, 1, 0, 1, 6, 6, 6, 6};
    return t[i];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor state
  int  s_cnt [8];
  int  p_cnt, clr_cnt, last_idx, order_bad, run_bad, max_step;
  int  clr_addr;
  bit  run_at_edge = 1'b0;

  task automatic mon_clear();
    for (int i = 0; i < 8; i++) s_cnt[i] = 0;
    p_cnt = 0; clr_cnt = 0; last_idx = -1; order_bad = 0;
    run_bad = 0; max_step = -1; clr_addr = -1;
  endtask

  always @(posedge clk) begin
    run_at_edge <= cpu_run;
    cycles++;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if ($countones(strobe) > 1) order_bad++;
      if ((strobe != 0) && step_pulse) order_bad++;
      for (int i = 0; i < 8; i++) begin
        if (strobe[i]) begin
          s_cnt[i]++;
          if (i <= last_idx || p_cnt > 0) order_bad++;
          last_idx = i;
        end
      end
      if (step_pulse) p_cnt++;
      if (seq_clr) begin
        clr_cnt++;
        clr_addr = int'(seq_addr);
      end
      if (seq_busy && int'(seq_addr[3:0]) > max_step) max_step = int'(seq_addr[3:0]);
      if (run_at_edge && ((strobe != 0) || step_pulse || seq_clr)) run_bad++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_busy(input bit level, input string tag);
    int t = 0;
    while (seq_busy !== level && t < 1000) begin
      tick(1);
      t++;
    end
    check(seq_busy === level, tag, int'(seq_busy), int'(level));
  endtask

  // Run one command: keys = active-low lines, idx = expected command.
  // mode 0 plain, 1 freeze with cpu_run mid-way, 2 lower key 0 mid-way.
  task automatic run_cmd(input logic [7:0] keys, input int idx, input int mode);
    mon_clear();
    key_n = keys;
    wait_busy(1'b1, "R3 start");
    if (mode == 1) begin
      tick(2 * TDIV + 1);
      cpu_run = 1'b1;
      tick(40);
      check(seq_busy === 1'b1, "R4 frozen busy", int'(seq_busy), 1);
      cpu_run = 1'b0;
    end
    if (mode == 2) begin
      tick(TDIV + 1);
      key_n = keys & 8'hFE;
    end
    wait_busy(1'b0, "R8 done");
    tick(3);
    check(seq_addr == 8'o177, "R8 park held", int'(seq_addr), 8'o177);
    if (mode != 2)
      check(cmd_code == e_code(idx), "R1/R2 code", int'(cmd_code), int'(e_code(idx)));
    tick(6 * TDIV);
    check(seq_busy === 1'b0 && clr_cnt == 1, "R9 no retrigger", clr_cnt, 1);
    key_n = 8'hFF;
    tick(4);
    check(seq_addr == 8'o177, "R8 park released", int'(seq_addr), 8'o177);
    check(cmd_code == 4'hF, "R1 none", int'(cmd_code), 15);
    check(clr_addr == int'({e_code(idx), 4'h0}), "R3 clear addr", clr_addr,
          int'({e_code(idx), 4'h0}));
    for (int i = 0; i < 8; i++)
      check(s_cnt[i] == int'(e_mask(idx)[i]), $sformatf("R5 cmd%0d S%0d", idx, i + 1),
            s_cnt[i], int'(e_mask(idx)[i]));
    check(p_cnt == e_pulses(idx), $sformatf("R6 cmd%0d pulses", idx), p_cnt, e_pulses(idx));
    check(order_bad == 0, $sformatf("R7 cmd%0d order", idx), order_bad, 0);
    check(max_step == $countones(e_mask(idx)) + e_pulses(idx),
          $sformatf("R8 cmd%0d last step", idx), max_step,
          $countones(e_mask(idx)) + e_pulses(idx));
    check(run_bad == 0, "R4 quiet while running", run_bad, 0);
  endtask

  initial begin
    mon_clear();
    tick(5);
    rst = 1'b0;
    tick(2);
    // R10 reset state
    check(seq_addr == 8'o177, "R10 addr", int'(seq_addr), 8'o177);
    check(cmd_code == 4'hF, "R10 code", int'(cmd_code), 15);
    check(!seq_busy && !seq_clr && !step_pulse && strobe == 0, "R10 outputs",
          int'({seq_busy, seq_clr, step_pulse, strobe}), 0);

    // Every command on its own
    for (int c = 0; c < 8; c++) begin
      run_cmd(~(8'h01 << c), c, 0);
      tick(3);
    end

    // R2 priority: deposit and accumulator load together -> deposit
    run_cmd(~8'h24, 2, 0);
    // R2 priority: input and output together -> input
    run_cmd(~8'hC0, 6, 0);
    // R4 freeze mid-sequence on output
    run_cmd(~8'h80, 7, 1);
    // R9 examine lowered while output busy is ignored
    run_cmd(~8'h80, 7, 2);

    // R4 press while running starts nothing
    mon_clear();
    cpu_run = 1'b1;
    tick(1);
    key_n = ~8'h04;
    tick(30);
    check(seq_busy === 1'b0 && clr_cnt == 0, "R4 press while running", clr_cnt, 0);
    check(seq_addr == 8'o177, "R4 addr unchanged", int'(seq_addr), 8'o177);
    key_n = 8'hFF;
    tick(2);
    cpu_run = 1'b0;
    tick(20);
    check(seq_busy === 1'b0 && run_bad == 0, "R4 no late start", run_bad, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule